// File: doc/BRIEF.md
# HDLC Receive Event Monitor

This block sits beside an HDLC receiver and watches its destuffed serial bit stream one bit-valid strobe at a time. It detects opening and closing flags, abort runs and the go-ahead sequence. It counts the bits of the current packet so that an abort is honoured only after a minimum length. It also tags every end-of-packet byte that the receiver writes into its Rx FIFO as good, aborted or invalid. When a byte write meets a full Rx FIFO, it reports an overflow and holds the receiver disabled until the next flag arrives.

A small state machine tracks where the link stands. It has three states:

- `ST_HUNT`: waiting for an opening flag.
- `ST_PKT`: a packet is open and bits are being counted.
- `ST_BLOCK`: reception is disabled after an overflow.

The transitions are:

- HUNT→PKT on a flag.
- PKT→PKT on a flag. If the packet held data, this also closes it.
- PKT→HUNT on a qualified abort.
- PKT→BLOCK on an overflow.
- BLOCK→PKT on a flag.

Every event output is a registered one-clock pulse. It appears in the clock cycle after the strobe that completed the pattern.

Top module: `hdlc_rx_evmon`

## Requirements
- R1: While reset is active, and directly after it, `rx_en` is 1, every pulse output is 0 and `eop_kind` is 0. The state is hunting.
- R2: A flag is the bit sequence 0,1,1,1,1,1,1,0, oldest bit first. In hunting it opens a packet without raising `eop_wr_pulse`. In an open packet, let P be the bits counted since the previous flag minus the 8 flag bits. A flag with P > 0 raises `eop_wr_pulse`. A flag with P ≤ 0 (back-to-back flags) raises nothing.
- R3: `eop_kind` is valid only with `eop_wr_pulse` and is 0 at all other times. A closing flag gives 0 (good) when P ≥ 26 and P is a multiple of 8. Otherwise it gives 2 (invalid).
- R4: An abort is seven 1s that follow a 0. It is qualified when at least 26 bits were counted since the flag before its first 1. A qualified abort in an open packet raises `abort_pulse` and `eop_wr_pulse` with `eop_kind` = 1, and returns the monitor to hunting. Further 1s raise no more pulses.
- R5: An abort with fewer than 26 preceding bits is ignored. No pulse is raised and the packet stays open, so its later closing flag is still tagged.
- R6: The bit sequence 0,1,1,1,1,1,1,1,0 raises `ga_pulse` in any state.
- R7: In an open packet, a byte write is attempted on every strobe that makes the bit count a nonzero multiple of 8 without closing the packet. If `fifo_full` is 1 at that strobe, `ovfl_pulse` rises and `rx_en` drops in the same cycle.
- R8: While the receiver is disabled, no abort, end-of-packet or overflow pulse is raised. The next flag sets `rx_en` to 1 and opens a packet without an end-of-packet pulse.
- R9: The packet bit counter (CNT_W bits) saturates at 2^CNT_W−1 instead of wrapping. With the default CNT_W = 8, a packet of 288 data bits therefore closes as invalid.
- R10: Each pulse lasts one clock cycle. It appears only in the cycle after a sampled strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Destuffed receive bit |
| bit_vld | input | 1 | Strobe marking `rx_bit` as a new bit |
| fifo_full | input | 1 | Rx FIFO full flag |
| ga_pulse | output | 1 | Go-ahead sequence seen |
| abort_pulse | output | 1 | Qualified abort seen |
| eop_wr_pulse | output | 1 | End-of-packet byte written |
| eop_kind | output | 2 | Tag for the end-of-packet byte: 0 good, 1 abort, 2 invalid |
| ovfl_pulse | output | 1 | Byte write attempted into a full Rx FIFO |
| rx_en | output | 1 | Receiver enabled level |

## Verification
The hardest case to reach from the ports is saturation of the bit counter. A wrapping counter and a saturating one disagree only after more than 255 bits without a flag. The stimulus sends 288 zeros, a length whose wrapped count would give a good close, so only saturation makes the close invalid. The abort threshold is probed on both sides, with 25 and then 26 zeros before the run of 1s. The ignored abort is followed by a 0 so that the same bits also form a go-ahead. The overflow path is driven twice, both before and after a flag re-enables the receiver.

// File: rtl/hdlc_mon_pkg.sv
package hdlc_mon_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_PKT   = 2'd1,
        ST_BLOCK = 2'd2
    } mon_state_e;

    typedef enum logic [1:0] {
        EOP_GOOD  = 2'd0,
        EOP_ABORT = 2'd1,
        EOP_BAD   = 2'd2
    } eop_kind_e;

    localparam int FLAG_LEN  = 8;
    localparam int ABORT_RUN = 7;
    localparam int GA_LEN    = 9;
    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/hdlc_pat_det.sv
// Serial pattern detector: history advances only on bit strobes; hits are
// combinational on the strobe that completes each pattern.
module hdlc_pat_det
    import hdlc_mon_pkg::*;
#(
    parameter int HIST_W = GA_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic rx_bit,
    output logic flag_hit,
    output logic abort_hit,
    output logic ga_hit
);
    localparam int SH_W = HIST_W - 1;
    localparam logic [FLAG_LEN-1:0] FLAG_PAT  = {1'b0, {(FLAG_LEN-2){1'b1}}, 1'b0};
    localparam logic [FLAG_LEN-1:0] ABORT_PAT = {1'b0, {ABORT_RUN{1'b1}}};
    localparam logic [GA_LEN-1:0]   GA_PAT    = {1'b0, {(GA_LEN-2){1'b1}}, 1'b0};

    logic [SH_W-1:0] sh_q;
    logic [HIST_W-1:0] win;

    assign win = {sh_q, rx_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (bit_vld) begin
            sh_q <= win[SH_W-1:0];
        end
    end

    assign flag_hit  = bit_vld && (win[FLAG_LEN-1:0] == FLAG_PAT);
    assign abort_hit = bit_vld && (win[FLAG_LEN-1:0] == ABORT_PAT);
    assign ga_hit    = bit_vld && (win[GA_LEN-1:0]   == GA_PAT);

endmodule

// File: rtl/hdlc_bit_cnt.sv
// Saturating packet bit counter; cnt_nxt is the count including this strobe.
module hdlc_bit_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    assign cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/hdlc_rx_evmon.sv
module hdlc_rx_evmon
    import hdlc_mon_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int MIN_BITS = 26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    input  logic       bit_vld,
    input  logic       fifo_full,
    output logic       ga_pulse,
    output logic       abort_pulse,
    output logic       eop_wr_pulse,
    output logic [1:0] eop_kind,
    output logic       ovfl_pulse,
    output logic       rx_en
);
    localparam int BYTE_LG = $clog2(BYTE_BITS);
    localparam logic [CNT_W-1:0] IDLE_MAX  = CNT_W'(FLAG_LEN);
    localparam logic [CNT_W-1:0] CLOSE_MIN = CNT_W'(MIN_BITS + FLAG_LEN);
    localparam logic [CNT_W-1:0] ABORT_MIN = CNT_W'(MIN_BITS + ABORT_RUN);

    logic             flag_hit, abort_hit, ga_hit;
    logic [CNT_W-1:0] cnt_nxt;
    logic             byte_end;

    mon_state_e st_q, st_d;
    logic       ga_d, ab_d, eop_d, ovfl_d;
    eop_kind_e  kind_d;

    hdlc_pat_det #(.HIST_W(GA_LEN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .rx_bit   (rx_bit),
        .flag_hit (flag_hit),
        .abort_hit(abort_hit),
        .ga_hit   (ga_hit)
    );

    hdlc_bit_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (bit_vld),
        .clr    (flag_hit),
        .cnt_nxt(cnt_nxt)
    );

    assign byte_end = (cnt_nxt[BYTE_LG-1:0] == '0);

    // next-state and event decision
    always_comb begin
        st_d   = st_q;
        ga_d   = ga_hit;
        ab_d   = 1'b0;
        eop_d  = 1'b0;
        ovfl_d = 1'b0;
        kind_d = EOP_GOOD;
        unique case (st_q)
            ST_HUNT: begin
                if (flag_hit) st_d = ST_PKT;
            end
            ST_PKT: begin
                if (flag_hit) begin
                    if (cnt_nxt > IDLE_MAX) begin
                        eop_d  = 1'b1;
                        kind_d = (cnt_nxt >= CLOSE_MIN && byte_end) ? EOP_GOOD : EOP_BAD;
                    end
                end else if (abort_hit && cnt_nxt >= ABORT_MIN) begin
                    ab_d   = 1'b1;
                    eop_d  = 1'b1;
                    kind_d = EOP_ABORT;
                    st_d   = ST_HUNT;
                end else if (bit_vld && byte_end && fifo_full) begin
                    ovfl_d = 1'b1;
                    st_d   = ST_BLOCK;
                end
            end
            ST_BLOCK: begin
                if (flag_hit) st_d = ST_PKT;
            end
            default: st_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ga_pulse     <= 1'b0;
            abort_pulse  <= 1'b0;
            eop_wr_pulse <= 1'b0;
            eop_kind     <= EOP_GOOD;
            ovfl_pulse   <= 1'b0;
            rx_en        <= 1'b1;
        end else begin
            ga_pulse     <= ga_d;
            abort_pulse  <= ab_d;
            eop_wr_pulse <= eop_d;
            eop_kind     <= eop_d ? kind_d : EOP_GOOD;
            ovfl_pulse   <= ovfl_d;
            rx_en        <= (st_d != ST_BLOCK);
        end
    end

endmodule

// File: rtl/hdlc_rx_evmon_chk.sv
module hdlc_rx_evmon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       ga_pulse,
    input logic       abort_pulse,
    input logic       eop_wr_pulse,
    input logic [1:0] eop_kind,
    input logic       ovfl_pulse,
    input logic       rx_en
);
    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ga_pulse || abort_pulse || eop_wr_pulse || ovfl_pulse)
        |=> !(ga_pulse || abort_pulse || eop_wr_pulse || ovfl_pulse));

    p_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !(ga_pulse || abort_pulse || eop_wr_pulse || ovfl_pulse));

    p_abort_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (eop_wr_pulse && eop_kind == 2'd1));

    p_kind_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !eop_wr_pulse |-> (eop_kind == 2'd0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl_pulse |-> !rx_en);

    p_blocked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_en) |-> !(abort_pulse || eop_wr_pulse || ovfl_pulse));

    p_reenable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> $past(bit_vld));

endmodule

bind hdlc_rx_evmon hdlc_rx_evmon_chk u_chk (.*);

// File: tb/tb_hdlc_rx_evmon.sv
module tb_hdlc_rx_evmon;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       bit_vld = 1'b0;
    logic       fifo_full = 1'b0;
    logic       ga_pulse, abort_pulse, eop_wr_pulse, ovfl_pulse, rx_en;
    logic [1:0] eop_kind;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic exp_en = 1'b1;

    logic [6:0] exp_q[$];
    string      tag_q[$];

    always #10ns clk = ~clk;

    hdlc_rx_evmon dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_vld(bit_vld),
        .fifo_full(fifo_full), .ga_pulse(ga_pulse), .abort_pulse(abort_pulse),
        .eop_wr_pulse(eop_wr_pulse), .eop_kind(eop_kind),
        .ovfl_pulse(ovfl_pulse), .rx_en(rx_en)
    );

    // {rx_en, ga, abort, eop, kind[1:0], ovfl}
    function automatic logic [6:0] ev(input logic en, input logic ga, input logic ab,
                                      input logic eop, input logic [1:0] kind, input logic ov);
        return {en, ga, ab, eop, kind, ov};
    endfunction

    function automatic logic [6:0] quiet();
        return ev(exp_en, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    endfunction

    task automatic send(input logic b, input logic [6:0] e, input string tag);
        @(negedge clk);
        rx_bit  = b;
        bit_vld = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic run(input int n, input logic b, input string tag);
        for (int i = 0; i < n; i++) send(b, quiet(), tag);
    endtask

    // six leading bits quiet (0,1,1,1,1,1), then 1, then closing 0 with given result
    task automatic flag(input logic [6:0] last_e, input string tag);
        send(1'b0, quiet(), tag);
        for (int i = 0; i < 6; i++) send(1'b1, quiet(), tag);
        send(1'b0, last_e, tag);
    endtask

    // monitor / scoreboard
    initial begin
        @(posedge rst_n);
        forever begin
            logic v;
            logic [6:0] got, e;
            string t;
            @(posedge clk);
            v = bit_vld;
            @(negedge clk);
            got = {rx_en, ga_pulse, abort_pulse, eop_wr_pulse, eop_kind, ovfl_pulse};
            checks++;
            if (v) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got !== e) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b", t, got, e);
                end
            end else if (got[5:0] !== 6'b0) begin
                errors++;
                $display("FAIL R10 pulse without strobe: got %b expected %b", got[5:0], 6'b0);
            end
        end
    end

    initial begin
        #3000us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({rx_en, ga_pulse, abort_pulse, eop_wr_pulse, eop_kind, ovfl_pulse} !== 7'b1000000) begin
            errors++;
            $display("FAIL R1 reset: got %b expected %b",
                     {rx_en, ga_pulse, abort_pulse, eop_wr_pulse, eop_kind, ovfl_pulse}, 7'b1000000);
        end
        rst_n = 1'b1;

        // R2: opening flag from hunting, no eop
        flag(quiet(), "R2 open");
        // R2/R3: 32 data bits, good close
        run(32, 1'b0, "R7 no write fault");
        flag(ev(1, 0, 0, 1, 2'd0, 0), "R3 good close");
        // R2: back-to-back flag, nothing
        flag(quiet(), "R2 idle flag");
        // R3: short packet invalid
        run(16, 1'b0, "R3 data");
        flag(ev(1, 0, 0, 1, 2'd2, 0), "R3 short invalid");
        // R3: non-multiple of 8 invalid
        run(30, 1'b0, "R3 data");
        flag(ev(1, 0, 0, 1, 2'd2, 0), "R3 odd invalid");
        // R5 and R6: early abort ignored, then go-ahead
        run(25, 1'b0, "R5 data");
        run(7, 1'b1, "R5 early abort ignored");
        send(1'b0, ev(1, 1, 0, 0, 2'd0, 0), "R6 go-ahead");
        flag(ev(1, 0, 0, 1, 2'd2, 0), "R5 packet still open");
        // R4: qualified abort, extra ones silent, back to hunting
        run(26, 1'b0, "R4 data");
        run(6, 1'b1, "R4 run");
        send(1'b1, ev(1, 0, 1, 1, 2'd1, 0), "R4 abort");
        run(2, 1'b1, "R4 extra ones");
        run(24, 1'b0, "R4 hunting");
        flag(quiet(), "R4 hunt flag opens without eop");
        // R7/R8: overflow, blocked, re-enable
        fifo_full = 1'b1;
        run(7, 1'b0, "R7 data");
        exp_en = 1'b0;
        send(1'b0, ev(0, 0, 0, 0, 2'd0, 1), "R7 overflow");
        run(40, 1'b0, "R8 blocked quiet");
        exp_en = 1'b1;
        send(1'b0, ev(0, 0, 0, 0, 2'd0, 0), "R8 flag");
        for (int i = 0; i < 6; i++) send(1'b1, ev(0, 0, 0, 0, 2'd0, 0), "R8 flag");
        send(1'b0, ev(1, 0, 0, 0, 2'd0, 0), "R8 re-enable");
        run(7, 1'b0, "R7 data");
        exp_en = 1'b0;
        send(1'b0, ev(0, 0, 0, 0, 2'd0, 1), "R7 overflow again");
        fifo_full = 1'b0;
        exp_en = 1'b1;
        send(1'b0, ev(0, 0, 0, 0, 2'd0, 0), "R8 flag");
        for (int i = 0; i < 6; i++) send(1'b1, ev(0, 0, 0, 0, 2'd0, 0), "R8 flag");
        send(1'b0, ev(1, 0, 0, 0, 2'd0, 0), "R8 re-enable");
        // R9: saturation makes a 288-bit packet invalid
        run(288, 1'b0, "R9 long data");
        flag(ev(1, 0, 0, 1, 2'd2, 0), "R9 saturated close");
        run(4, 1'b0, "R10 tail");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule